// File: doc/BRIEF.md
# Vector Clock Race Engine

The engine tracks happens-before order between a small fixed set of threads and judges every memory access in an event stream against it. Each thread owns a vector clock with one entry per thread. Locks carry their own vector clocks in a small table, and every tracked address carries a last-write vector and a last-reads vector in a second table. Both tables are indexed by a small object ID.

An event names a thread, an object ID and one of four operations: take a lock, give a lock back, read an address or write an address. Lock events move ordering information between threads through the lock vectors. Read and write events compare the address's history against the issuing thread's clock and report whether the access races with an earlier access that is not ordered before it. The element-wise maximum and element-wise comparison work on all thread lanes at once, so each event finishes in a fixed number of cycles whatever the thread count.

The engine accepts one event per cycle. Each event returns exactly one result two cycles after it is accepted. The result carries the race flag and echoes the thread and object IDs, so a consumer can match the flag to its access. A clock that would run past its largest value sets a sticky error flag.

Top module: `vc_race_engine`

## Requirements
- R1: `ev_ready` is high whenever reset is released. An event accepted in cycle c gives `res_valid` high in cycle c+2 with `res_tid` and `res_obj` equal to its thread and object IDs. `res_race` is low whenever `res_valid` is low.
- R2: After reset every lock, read and write vector is all zeros. Thread t's clock has entry t equal to 1 and all other entries 0.
- R3: Operation code 0 (acquire) sets the thread's clock to the lane-wise maximum of itself and the named lock's vector.
- R4: Operation code 1 (release) copies the thread's clock into the named lock's vector. After the copy, it adds one to the thread's own entry.
- R5: Operation code 2 (read) reports a race when some lane of the address's write vector is greater than the same lane of the thread's clock.
- R6: A read without a race sets lane t of the address's read vector to the thread's own clock entry and leaves the other lanes unchanged.
- R7: Operation code 3 (write) reports a race unless every lane of both the write vector and the read vector is at most the matching lane of the thread's clock.
- R8: A write without a race clears the read vector. It then sets the write vector to hold only the thread's own clock entry in lane t, so the write vector never has more than one non-zero lane.
- R9: A read or write that reports a race leaves both vectors of that address unchanged.
- R10: A release while the thread's own entry is at its largest value (all ones) keeps that entry unchanged and sets `err_ovf`. Once set, `err_ovf` stays set until reset.
- R11: Acquire and release events always return `res_race` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered this cycle |
| ev_ready | output | 1 | Engine accepts an event this cycle |
| ev_op | input | 2 | 0 acquire, 1 release, 2 read, 3 write |
| ev_tid | input | TID_W | Issuing thread |
| ev_obj | input | OBJ_W | Lock ID for lock events, address ID for accesses |
| res_valid | output | 1 | One-cycle result strobe |
| res_race | output | 1 | Race found for the event being reported |
| res_tid | output | TID_W | Thread ID of the event being reported |
| res_obj | output | OBJ_W | Object ID of the event being reported |
| err_ovf | output | 1 | Sticky clock overflow flag |

## Verification
Thread, lock and address vectors are visible only through later race flags, so a wrong entry shows up as a race flag that is wrong on some later access. A lost union or a skipped increment shows up at the next access that depends on the ordering it should have carried. A metadata update that should have been held back after a race makes a later access by the original owner report a race where none exists. The bench keeps its own full model of every vector and compares each returned flag against that model, so a corrupted vector is caught at the first access that reads it, usually within a few events.

// File: rtl/vcre_pkg.sv
package vcre_pkg;
  typedef enum logic [1:0] {
    OP_ACQ = 2'd0,
    OP_REL = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } ev_op_t;
endpackage

// File: rtl/vc_join.sv
// Lane-wise maximum of two vector clocks, all lanes at once.
module vc_join #(
  parameter int NT = 8,
  parameter int CW = 16
) (
  input  logic [NT-1:0][CW-1:0] a,
  input  logic [NT-1:0][CW-1:0] b,
  output logic [NT-1:0][CW-1:0] y
);
  function automatic logic [CW-1:0] lane_max(input logic [CW-1:0] p, input logic [CW-1:0] q);
    return (p > q) ? p : q;
  endfunction

  for (genvar i = 0; i < NT; i++) begin : g_lane
    assign y[i] = lane_max(a[i], b[i]);
  end
endmodule

// File: rtl/vc_order.sv
// le is high when every lane of a is at most the matching lane of b.
module vc_order #(
  parameter int NT = 8,
  parameter int CW = 16
) (
  input  logic [NT-1:0][CW-1:0] a,
  input  logic [NT-1:0][CW-1:0] b,
  output logic                  le
);
  logic [NT-1:0] lane_ok;

  for (genvar i = 0; i < NT; i++) begin : g_lane
    assign lane_ok[i] = (a[i] <= b[i]);
  end

  assign le = &lane_ok;
endmodule

// File: rtl/vc_meta_next.sv
// Next-state for one address's read and write vectors.
module vc_meta_next #(
  parameter int NT    = 8,
  parameter int CW    = 16,
  parameter int TID_W = 3
) (
  input  logic                  do_rd,
  input  logic                  do_wr,
  input  logic [TID_W-1:0]      tid,
  input  logic [CW-1:0]         own,
  input  logic [NT-1:0][CW-1:0] rv_i,
  input  logic [NT-1:0][CW-1:0] wv_i,
  output logic [NT-1:0][CW-1:0] rv_o,
  output logic [NT-1:0][CW-1:0] wv_o,
  output logic                  commit
);
  function automatic logic [NT-1:0][CW-1:0] put_lane(
    input logic [NT-1:0][CW-1:0] v, input logic [TID_W-1:0] k, input logic [CW-1:0] val);
    logic [NT-1:0][CW-1:0] r;
    r = v;
    r[k] = val;
    return r;
  endfunction

  always_comb begin
    rv_o = rv_i;
    wv_o = wv_i;
    if (do_wr) begin
      rv_o = '0;
      wv_o = put_lane('0, tid, own);
    end else if (do_rd) begin
      rv_o = put_lane(rv_i, tid, own);
    end
  end

  assign commit = do_rd | do_wr;
endmodule

// File: rtl/vc_race_engine.sv
module vc_race_engine
  import vcre_pkg::*;
#(
  parameter int NT   = 8,
  parameter int NOBJ = 8,
  parameter int CW   = 16,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int OBJ_W = (NOBJ > 1) ? $clog2(NOBJ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [1:0]       ev_op,
  input  logic [TID_W-1:0] ev_tid,
  input  logic [OBJ_W-1:0] ev_obj,
  output logic             res_valid,
  output logic             res_race,
  output logic [TID_W-1:0] res_tid,
  output logic [OBJ_W-1:0] res_obj,
  output logic             err_ovf
);
  localparam logic [CW-1:0] CLK_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] CLK_ONE = CW'(1);

  typedef logic [NT-1:0][CW-1:0] vc_t;

  vc_t thr_vc  [NT];
  vc_t lock_vc [NOBJ];
  vc_t rd_vc   [NOBJ];
  vc_t wr_vc   [NOBJ];

  // Stage 1: captured event
  logic             s1_valid;
  logic [1:0]       s1_op;
  logic [TID_W-1:0] s1_tid;
  logic [OBJ_W-1:0] s1_obj;
  logic [1:0]       res_op;

  // Named internal events
  logic    is_acq, is_rel, is_rd, is_wr;
  vc_t     cur_c, lk_v, rv, wv, acq_vc, rv_n, wv_n;
  logic    w_le, r_le;
  logic    race_hit, bump_ovf, meta_commit;
  logic [CW-1:0] own, own_next;

  assign ev_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_tid   <= '0;
      s1_obj   <= '0;
    end else begin
      s1_valid <= ev_valid & ev_ready;
      s1_op    <= ev_op;
      s1_tid   <= ev_tid;
      s1_obj   <= ev_obj;
    end
  end

  assign is_acq = s1_valid && (s1_op == OP_ACQ);
  assign is_rel = s1_valid && (s1_op == OP_REL);
  assign is_rd  = s1_valid && (s1_op == OP_RD);
  assign is_wr  = s1_valid && (s1_op == OP_WR);

  assign cur_c = thr_vc[s1_tid];
  assign own   = cur_c[s1_tid];
  assign lk_v  = lock_vc[s1_obj];
  assign rv    = rd_vc[s1_obj];
  assign wv    = wr_vc[s1_obj];

  vc_join #(.NT(NT), .CW(CW)) u_join (.a(cur_c), .b(lk_v), .y(acq_vc));
  vc_order #(.NT(NT), .CW(CW)) u_wr_ord (.a(wv), .b(cur_c), .le(w_le));
  vc_order #(.NT(NT), .CW(CW)) u_rd_ord (.a(rv), .b(cur_c), .le(r_le));

  assign race_hit = (is_rd && !w_le) || (is_wr && !(w_le && r_le));
  assign bump_ovf = is_rel && (own == CLK_MAX);
  assign own_next = bump_ovf ? own : own + CLK_ONE;

  vc_meta_next #(.NT(NT), .CW(CW), .TID_W(TID_W)) u_meta (
    .do_rd  (is_rd && !race_hit),
    .do_wr  (is_wr && !race_hit),
    .tid    (s1_tid),
    .own    (own),
    .rv_i   (rv),
    .wv_i   (wv),
    .rv_o   (rv_n),
    .wv_o   (wv_n),
    .commit (meta_commit)
  );

  // Stage 2: state update and result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++)
        for (int u = 0; u < NT; u++)
          thr_vc[t][u] <= (t == u) ? CLK_ONE : '0;
      for (int m = 0; m < NOBJ; m++) begin
        lock_vc[m] <= '0;
        rd_vc[m]   <= '0;
        wr_vc[m]   <= '0;
      end
      err_ovf   <= 1'b0;
      res_valid <= 1'b0;
      res_race  <= 1'b0;
      res_tid   <= '0;
      res_obj   <= '0;
      res_op    <= '0;
    end else begin
      if (is_acq) thr_vc[s1_tid] <= acq_vc;
      if (is_rel) begin
        lock_vc[s1_obj]        <= cur_c;
        thr_vc[s1_tid][s1_tid] <= own_next;
      end
      if (meta_commit) begin
        rd_vc[s1_obj] <= rv_n;
        wr_vc[s1_obj] <= wv_n;
      end
      err_ovf   <= err_ovf | bump_ovf;
      res_valid <= s1_valid;
      res_race  <= race_hit;
      res_tid   <= s1_tid;
      res_obj   <= s1_obj;
      res_op    <= s1_op;
    end
  end
endmodule

// File: rtl/vc_race_engine_chk.sv
module vc_race_engine_chk #(
  parameter int NT = 8,
  parameter int CW = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ev_valid,
  input logic                  ev_ready,
  input logic                  res_valid,
  input logic                  res_race,
  input logic [1:0]            res_op,
  input logic                  err_ovf,
  input logic                  s1_valid,
  input logic                  race_hit,
  input logic                  meta_commit,
  input logic                  bump_ovf,
  input logic [NT-1:0][CW-1:0] wv_next
);
  logic [NT-1:0] wnz;
  always_comb
    for (int i = 0; i < NT; i++) wnz[i] = (wv_next[i] != '0);

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n) ev_ready);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |-> ##2 res_valid);
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_race);
  assert_lock_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_op[1]) |-> !res_race);
  assert_race_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && race_hit) |-> !meta_commit);
  assert_single_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meta_commit |-> ($countones(wnz) <= 1));
  assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bump_ovf |=> err_ovf);
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf);
endmodule

bind vc_race_engine vc_race_engine_chk #(.NT(NT), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_valid    (ev_valid),
  .ev_ready    (ev_ready),
  .res_valid   (res_valid),
  .res_race    (res_race),
  .res_op      (res_op),
  .err_ovf     (err_ovf),
  .s1_valid    (s1_valid),
  .race_hit    (race_hit),
  .meta_commit (meta_commit),
  .bump_ovf    (bump_ovf),
  .wv_next     (wv_n)
);

// File: tb/tb_vc_race_engine.sv
module tb_vc_race_engine;
  localparam int NT = 8;
  localparam int NOBJ = 8;
  localparam int CW = 16;
  localparam int TID_W = 3;
  localparam int OBJ_W = 3;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ev_valid = 1'b0;
  logic             ev_ready;
  logic [1:0]       ev_op = '0;
  logic [TID_W-1:0] ev_tid = '0;
  logic [OBJ_W-1:0] ev_obj = '0;
  logic             res_valid, res_race, err_ovf;
  logic [TID_W-1:0] res_tid;
  logic [OBJ_W-1:0] res_obj;

  int checks = 0;
  int errors = 0;

  // Bench model of all vectors
  int mc [NT][NT];
  int ml [NOBJ][NT];
  int mr [NOBJ][NT];
  int mw [NOBJ][NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_race_engine #(.NT(NT), .NOBJ(NOBJ), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_op(ev_op), .ev_tid(ev_tid), .ev_obj(ev_obj), .res_valid(res_valid),
    .res_race(res_race), .res_tid(res_tid), .res_obj(res_obj), .err_ovf(err_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int t = 0; t < NT; t++)
      for (int u = 0; u < NT; u++) mc[t][u] = (t == u) ? 1 : 0;
    for (int m = 0; m < NOBJ; m++)
      for (int u = 0; u < NT; u++) begin
        ml[m][u] = 0; mr[m][u] = 0; mw[m][u] = 0;
      end
  endfunction

  // Returns the expected race flag and advances the model.
  function automatic bit model_apply(input int op, input int t, input int m);
    bit w_late = 0, r_late = 0;
    for (int u = 0; u < NT; u++) begin
      if (mw[m][u] > mc[t][u]) w_late = 1;
      if (mr[m][u] > mc[t][u]) r_late = 1;
    end
    case (op)
      0: begin
        for (int u = 0; u < NT; u++) if (ml[m][u] > mc[t][u]) mc[t][u] = ml[m][u];
        return 0;
      end
      1: begin
        for (int u = 0; u < NT; u++) ml[m][u] = mc[t][u];
        if (mc[t][t] < CMAX) mc[t][t] = mc[t][t] + 1;
        return 0;
      end
      2: begin
        if (w_late) return 1;
        mr[m][t] = mc[t][t];
        return 0;
      end
      default: begin
        if (w_late || r_late) return 1;
        for (int u = 0; u < NT; u++) begin
          mr[m][u] = 0;
          mw[m][u] = (u == t) ? mc[t][t] : 0;
        end
        return 0;
      end
    endcase
  endfunction

  task automatic send(input int op, input int t, input int m, input string req);
    bit exp_race;
    exp_race = model_apply(op, t, m);
    @(negedge clk);
    ev_valid = 1'b1; ev_op = 2'(op); ev_tid = TID_W'(t); ev_obj = OBJ_W'(m);
    @(negedge clk);
    ev_valid = 1'b0;
    check(res_valid == 1'b0, "R1 early", int'(res_valid), 0);
    @(negedge clk);
    check(res_valid == 1'b1, "R1 valid", int'(res_valid), 1);
    check(res_tid == TID_W'(t) && res_obj == OBJ_W'(m), "R1 echo",
          int'({res_tid, res_obj}), (t << OBJ_W) | m);
    check(res_race == exp_race, req, int'(res_race), int'(exp_race));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ev_ready == 1'b1, "R1 ready", int'(ev_ready), 1);
    check(res_valid == 1'b0 && err_ovf == 1'b0, "R2 reset outputs",
          int'({res_valid, err_ovf}), 0);

    // R2: fresh address, then an unordered reader
    send(3, 0, 0, "R2 R7 fresh write");
    send(2, 1, 0, "R5 unordered read");
    // R9: racing write must not replace owner
    send(3, 0, 1, "R7 owner write");
    send(3, 1, 1, "R7 racing write");
    send(2, 0, 1, "R9 owner read after race");
    // R3 R4: ordering through a lock
    send(3, 0, 2, "R7 write A2");
    send(1, 0, 1, "R11 release");
    send(0, 1, 1, "R11 acquire");
    send(3, 1, 2, "R3 ordered write");
    send(3, 0, 2, "R8 stale owner write");
    // R4: increment after copy
    send(3, 0, 3, "R7 write A3");
    send(0, 1, 1, "R11 reacquire");
    send(3, 1, 3, "R4 increment after copy");
    // R6: read entry recorded
    send(2, 2, 4, "R6 fresh read");
    send(3, 3, 4, "R6 write after unordered read");
    send(2, 3, 4, "R5 reader vs empty write");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op, t, m;
      op = int'($urandom % 4);
      t  = int'($urandom % NT);
      m  = int'($urandom % 4);
      send(op, t, m, (op >= 2) ? "R5 R7 random access" : "R11 random lock");
    end

    // R10: drive thread 7 to the top of its range
    @(negedge clk);
    while (mc[7][7] != CMAX) begin
      void'(model_apply(1, 7, 7));
      ev_valid = 1'b1; ev_op = 2'd1; ev_tid = 3'd7; ev_obj = 3'd7;
      @(negedge clk);
    end
    ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(err_ovf == 1'b0, "R10 no early error", int'(err_ovf), 0);
    send(1, 7, 7, "R10 overflow release");
    check(err_ovf == 1'b1, "R10 error set", int'(err_ovf), 1);
    send(0, 6, 7, "R11 acquire saturated");
    send(2, 6, 5, "R5 read after overflow");
    check(err_ovf == 1'b1, "R10 error sticky", int'(err_ovf), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule